// File: doc/BRIEF.md
# Processor Reset Supervisor with Strobe Watchdog

This controller drives a pair of complementary reset lines, `rst` and `rst_n`, for a processor. It puts the processor into reset for three reasons. The first is a digital supply-fault flag from an external comparator. The second is a pushbutton line, active low and debounced. The third is a watchdog that expects the processor to pull the strobe line low from time to time. When the last active reason clears, the reset stays asserted for a fixed hold-off of 250 ms before it releases.

The watchdog starts from zero every time the reset releases. Software cannot turn it off. Only a falling edge on the strobe line clears its count before it times out. A 2-bit select input picks one of three timeouts. When the watchdog expires, a full reset with the same hold-off follows, and then the watchdog runs again.

All timing runs on a single tick-enable input, which pulses once per 0.5 ms by default. The tick period and every interval are parameters given in microseconds, and the tick counts are derived from them. The pushbutton and strobe lines pass through a two-flop synchronizer. The supply-fault flag is taken to be already synchronous to `clk`.

Top module: `reset_supervisor`

## Requirements
- R1: `rst_n` always equals the inverse of `rst`. Reset is active when `rst` is 1.
- R2: While `rst_sys_n` is low, `rst` is 1. After `rst_sys_n` goes high, `rst` stays 1 until 500 tick-carrying clock edges have passed (250 ms at a 0.5 ms tick).
- R3: When `power_fail` is 1 at a clock edge, `rst` is 1 after that edge. It stays 1 for as long as `power_fail` stays 1, however long that is.
- R4: Only clock edges where `tick` is 1 advance the hold-off. `rst` drops on the 500th such edge after the last edge at which any reset cause was present.
- R5: `pb_n` (0 means pressed) is synchronized by two flops. It then takes effect only after it has held its new level for 20 consecutive tick edges (10 ms). Shorter low pulses leave `rst` at 0. So does a train of short pulses separated by high gaps.
- R6: A debounced press sets `rst` to 1 on the clock edge after the debounced level falls. The hold-off is measured from the debounced release, not from the press.
- R7: `td_sel` selects the watchdog timeout in ticks: 2'b00 gives 125 (62.5 ms), 2'b01 gives 500 (250 ms), and 2'b10 or 2'b11 gives 1000 (500 ms). The expiry flag is registered, and `rst` rises one edge after it.
- R8: The watchdog count is held at zero while `rst` is 1. It begins counting from zero on the edge after `rst` drops.
- R9: A synchronized falling edge of `strobe` clears the watchdog count and starts a new timeout period. A rising edge has no effect.
- R10: Watchdog expiry causes a reset with the full hold-off. The watchdog then restarts. A supply fault or a pushbutton press overrides a timeout that is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_sys_n | input | 1 | Synchronous active-low reset of the controller itself |
| tick | input | 1 | Timing enable, one pulse per tick period (0.5 ms by default) |
| power_fail | input | 1 | Supply out-of-tolerance flag from the external comparator, synchronous |
| pb_n | input | 1 | Pushbutton reset request, active low, asynchronous and bouncy |
| strobe | input | 1 | Watchdog service line; falling edges restart the timeout |
| td_sel | input | 2 | Watchdog timeout select |
| rst | output | 1 | Processor reset, active high |
| rst_n | output | 1 | Processor reset, active low |

## Verification
Each result lands on a cycle fixed by the registers on its path:
- A supply fault shows on `rst` one edge after it is sampled.
- A press shows 23 edges after the input changes: two synchronizer flops, then 20 debounce ticks, then the reset register.
- A strobe fall clears the count three edges after it is driven.
- An expiry reaches `rst` one edge after the count hits its limit.
- The hold-off ends 500 ticks after the last edge that saw a cause.

For every stimulus, the scoreboard computes the absolute cycle at which `rst` must change, with a tick held at 1. It then checks the output one cycle before that point and on that exact cycle, so that an error of one cycle in any direction is caught. Between edges, the checks sample at the falling clock edge. The ignored cases, such as a short pushbutton glitch or a rising edge on the strobe, are checked on the reset outputs and by the exact expiry cycle that follows them.

// File: rtl/rsup_pkg.sv
// Shared definitions for the reset supervisor.
// Assumes all intervals are given in microseconds and rounded up to ticks.
package rsup_pkg;

    // Watchdog timeout select codes; both upper codes mean the longest period.
    typedef enum logic [1:0] {
        TD_SHORT = 2'b00,
        TD_MID   = 2'b01,
        TD_LONG  = 2'b10,
        TD_LONG2 = 2'b11
    } td_sel_e;

    // Convert an interval in microseconds into a whole number of ticks (round up).
    function automatic int unsigned us_to_ticks(input int unsigned us,
                                                input int unsigned tick_us);
        return (us + tick_us - 1) / tick_us;
    endfunction

endpackage

// File: rtl/rsup_sync2.sv
// Two-flop synchronizer for a bundle of independent asynchronous inputs.
// Assumes each bit is a slow level whose bits need no mutual coherence.
module rsup_sync2 #(
    parameter int unsigned     WIDTH = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_sys_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/rsup_debounce.sv
// Debouncer for the synchronized pushbutton level.
// The output takes a new level only after the input has disagreed with it
// on STABLE_TICKS consecutive tick edges; any agreement restarts the run.
// Assumes the input is already synchronous to clk; reset state is released (1).
module rsup_debounce #(
    parameter int unsigned STABLE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_sys_n,
    input  logic tick,
    input  logic raw,
    output logic level
);

    localparam int unsigned CW = $clog2(STABLE_TICKS + 1);

    logic [CW-1:0] run_q;
    logic          level_q;

    // Count consecutive disagreeing ticks and adopt the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            level_q <= 1'b1;
            run_q   <= '0;
        end else if (raw == level_q) begin
            run_q <= '0;
        end else if (tick) begin
            if (run_q == CW'(STABLE_TICKS - 1)) begin
                level_q <= raw;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level = level_q;

    // R5
    db_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        !tick |=> $stable(level_q));

endmodule

// File: rtl/rsup_wdog.sv
// Strobe watchdog. Counts ticks while the reset outputs are inactive and raises
// a one-cycle expiry pulse when the selected limit is reached.
// Assumes the long setting is the largest; a kick or an active reset clears the count.
module rsup_wdog
    import rsup_pkg::*;
#(
    parameter int unsigned TICK_US  = 500,
    parameter int unsigned SHORT_US = 62500,
    parameter int unsigned MID_US   = 250000,
    parameter int unsigned LONG_US  = 500000
) (
    input  logic       clk,
    input  logic       rst_sys_n,
    input  logic       tick,
    input  logic       hold,
    input  logic       kick,
    input  logic [1:0] td_sel,
    output logic       expire
);

    localparam int unsigned LIM_S = us_to_ticks(SHORT_US, TICK_US);
    localparam int unsigned LIM_M = us_to_ticks(MID_US, TICK_US);
    localparam int unsigned LIM_L = us_to_ticks(LONG_US, TICK_US);
    localparam int unsigned CW    = $clog2(LIM_L + 1);

    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_q;
    logic          expire_q;

    // Decode the timeout select into a tick limit.
    always_comb begin
        case (td_sel_e'(td_sel))
            TD_SHORT: limit = CW'(LIM_S);
            TD_MID:   limit = CW'(LIM_M);
            default:  limit = CW'(LIM_L);
        endcase
    end

    // Advance the timeout count; clear it on kick or while reset is active.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (hold || kick) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q >= limit - 1'b1) begin
                    cnt_q    <= '0;
                    expire_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign expire = expire_q;

    // R8
    wd_held_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        hold |=> (cnt_q == '0));

    // R9
    wd_kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        kick |=> (cnt_q == '0) && !expire_q);

    // R7
    wd_expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        expire_q |-> $past(tick) && !$past(hold));

endmodule

// File: rtl/reset_supervisor.sv
// Processor reset supervisor. It combines the supply-fault flag, the debounced
// pushbutton and the watchdog expiry into one reset request. It then holds the
// complementary reset outputs for a fixed hold-off after the last request clears.
// Assumes power_fail is synchronous to clk and tick is a one-cycle enable.
module reset_supervisor #(
    parameter int unsigned TICK_US     = 500,
    parameter int unsigned HOLD_US     = 250000,
    parameter int unsigned DEBOUNCE_US = 10000,
    parameter int unsigned WD_SHORT_US = 62500,
    parameter int unsigned WD_MID_US   = 250000,
    parameter int unsigned WD_LONG_US  = 500000
) (
    input  logic       clk,
    input  logic       rst_sys_n,
    input  logic       tick,
    input  logic       power_fail,
    input  logic       pb_n,
    input  logic       strobe,
    input  logic [1:0] td_sel,
    output logic       rst,
    output logic       rst_n
);

    import rsup_pkg::*;

    localparam int unsigned HOLD_TICKS = us_to_ticks(HOLD_US, TICK_US);
    localparam int unsigned DEB_TICKS  = us_to_ticks(DEBOUNCE_US, TICK_US);
    localparam int unsigned HW         = $clog2(HOLD_TICKS + 1);

    logic [1:0]    sync_out;
    logic          pb_s;
    logic          stb_s;
    logic          stb_prev_q;
    logic          kick;
    logic          pb_level;
    logic          wd_expire;
    logic          cause;
    logic          rst_q;
    logic [HW-1:0] hold_q;

    rsup_sync2 #(.WIDTH(2), .INIT(2'b11)) u_sync (
        .clk       (clk),
        .rst_sys_n (rst_sys_n),
        .d         ({pb_n, strobe}),
        .q         (sync_out)
    );

    assign pb_s  = sync_out[1];
    assign stb_s = sync_out[0];

    // Remember the previous synchronized strobe for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            stb_prev_q <= 1'b1;
        end else begin
            stb_prev_q <= stb_s;
        end
    end

    assign kick = stb_prev_q && !stb_s;

    rsup_debounce #(.STABLE_TICKS(DEB_TICKS)) u_debounce (
        .clk       (clk),
        .rst_sys_n (rst_sys_n),
        .tick      (tick),
        .raw       (pb_s),
        .level     (pb_level)
    );

    rsup_wdog #(
        .TICK_US  (TICK_US),
        .SHORT_US (WD_SHORT_US),
        .MID_US   (WD_MID_US),
        .LONG_US  (WD_LONG_US)
    ) u_wdog (
        .clk       (clk),
        .rst_sys_n (rst_sys_n),
        .tick      (tick),
        .hold      (rst_q),
        .kick      (kick),
        .td_sel    (td_sel),
        .expire    (wd_expire)
    );

    assign cause = power_fail || !pb_level || wd_expire;

    // Assert reset on any cause; release it after the hold-off has run out.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            rst_q  <= 1'b1;
            hold_q <= '0;
        end else if (cause) begin
            rst_q  <= 1'b1;
            hold_q <= '0;
        end else if (rst_q && tick) begin
            if (hold_q == HW'(HOLD_TICKS - 1)) begin
                rst_q  <= 1'b0;
                hold_q <= '0;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    assign rst   = rst_q;
    assign rst_n = !rst_q;

    // R3
    pf_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        power_fail |=> rst_q);

    // R6
    pb_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        !pb_level |=> rst_q);

    // R10
    expire_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        wd_expire |=> rst_q);

    // R4
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        $fell(rst_q) |-> $past(tick) && !$past(cause));

endmodule

// File: tb/reset_supervisor_bench.sv
// Scoreboard bench: the driver pushes (cycle, expected rst, requirement) items;
// a monitor on the falling clock edge pops items that fall due and compares.
module reset_supervisor_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_sys_n;
    logic       tick;
    logic       power_fail;
    logic       pb_n;
    logic       strobe;
    logic [1:0] td_sel;
    logic       rst;
    logic       rst_n;

    int   cyc    = 0;
    int   n_vec  = 0;
    int   n_bad  = 0;
    exp_t sb_q[$];

    int n0, r1, r2, r3, r4, f0, g0, r5, p0, q0, r6, a0;

    reset_supervisor u_reset_supervisor (
        .clk        (clk),
        .rst_sys_n  (rst_sys_n),
        .tick       (tick),
        .power_fail (power_fail),
        .pb_n       (pb_n),
        .strobe     (strobe),
        .td_sel     (td_sel),
        .rst        (rst),
        .rst_n      (rst_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int at, input logic val, input string tag);
        exp_t e;
        e.at  = at;
        e.val = val;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic kick_strobe(input int at);
        wait_until(at);
        strobe = 1'b0;
        wait_until(at + 5);
        strobe = 1'b1;
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Monitor: compare every item that is due at this falling edge (R1 on each).
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at <= cyc) begin
                n_vec++;
                if (sb_q[i].at != cyc || rst !== sb_q[i].val || rst_n !== ~sb_q[i].val) begin
                    n_bad++;
                    $display("FAIL %s/R1: cycle %0d (due %0d) rst=%b rst_n=%b expected rst=%b rst_n=%b",
                             sb_q[i].tag, cyc, sb_q[i].at, rst, rst_n,
                             sb_q[i].val, ~sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    // Watchdog for a hung run.
    initial begin
        #(CLK_PERIOD * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 100000", cyc);
        report();
        $finish;
    end

    // Driver.
    initial begin
        rst_sys_n  = 1'b0;
        tick       = 1'b0;
        power_fail = 1'b0;
        pb_n       = 1'b1;
        strobe     = 1'b1;
        td_sel     = 2'b00;

        // R2: reset state while the controller reset is low.
        wait_until(1);
        expect_at(2, 1'b1, "R2");
        wait_until(3);
        n0 = cyc;
        rst_sys_n = 1'b1;

        // R4: no ticks for 100 cycles, so the hold-off is delayed by that much.
        expect_at(n0 + 50, 1'b1, "R4");
        wait_until(n0 + 100);
        tick = 1'b1;
        expect_at(n0 + 599, 1'b1, "R2");
        expect_at(n0 + 600, 1'b0, "R2");
        r1 = n0 + 600;

        // R7/R8: short timeout, counted from the release edge.
        expect_at(r1 + 125, 1'b0, "R8");
        expect_at(r1 + 126, 1'b1, "R7");
        // R10: full hold-off after expiry.
        expect_at(r1 + 625, 1'b1, "R10");
        expect_at(r1 + 626, 1'b0, "R10");
        r2 = r1 + 626;
        wait_until(r1 + 300);
        td_sel = 2'b01;

        // R9: periodic falling edges keep the 250 ms watchdog quiet.
        kick_strobe(r2 + 200);
        kick_strobe(r2 + 500);
        expect_at(r2 + 650, 1'b0, "R9");
        kick_strobe(r2 + 800);
        expect_at(r2 + 950, 1'b0, "R9");
        a0 = r2 + 1100;
        expect_at(a0 + 503, 1'b0, "R9");
        expect_at(a0 + 504, 1'b1, "R7");
        kick_strobe(a0);
        r3 = a0 + 1004;
        wait_until(a0 + 700);
        td_sel = 2'b11;

        // R7: longest timeout with code 11.
        expect_at(r3 - 1, 1'b1, "R10");
        expect_at(r3, 1'b0, "R10");
        expect_at(r3 + 1000, 1'b0, "R7");
        expect_at(r3 + 1001, 1'b1, "R7");
        r4 = r3 + 1501;
        wait_until(r3 + 1200);
        td_sel = 2'b00;

        // R3/R10: supply fault overrides a running timeout for a long stretch.
        f0 = r4 + 100;
        expect_at(f0 + 1, 1'b1, "R3");
        expect_at(f0 + 1000, 1'b1, "R3");
        expect_at(f0 + 1500, 1'b1, "R3");
        wait_until(f0);
        power_fail = 1'b1;
        g0 = f0 + 1500;
        expect_at(g0 + 499, 1'b1, "R4");
        expect_at(g0 + 500, 1'b0, "R4");
        expect_at(g0 + 625, 1'b0, "R8");
        expect_at(g0 + 626, 1'b1, "R8");
        wait_until(g0);
        power_fail = 1'b0;
        r5 = g0 + 1126;
        wait_until(g0 + 800);
        td_sel = 2'b11;

        // R5/R6: debounced press and hold-off from the release.
        p0 = r5 + 50;
        expect_at(p0 + 22, 1'b0, "R5");
        expect_at(p0 + 23, 1'b1, "R6");
        wait_until(p0);
        pb_n = 1'b0;
        q0 = p0 + 600;
        expect_at(q0 + 521, 1'b1, "R6");
        expect_at(q0 + 522, 1'b0, "R6");
        wait_until(q0);
        pb_n = 1'b1;
        r6 = q0 + 522;

        // R5: short glitches separated by a brief high gap are ignored.
        expect_at(r6 + 160, 1'b0, "R5");
        expect_at(r6 + 400, 1'b0, "R5");
        expect_at(r6 + 1000, 1'b0, "R10");
        expect_at(r6 + 1001, 1'b1, "R10");
        wait_until(r6 + 100);
        pb_n = 1'b0;
        wait_until(r6 + 115);
        pb_n = 1'b1;
        wait_until(r6 + 118);
        pb_n = 1'b0;
        wait_until(r6 + 133);
        pb_n = 1'b1;

        wait_until(r6 + 1010);
        if (sb_q.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        report();
        $finish;
    end

endmodule